// File: doc/BRIEF.md
# Terminal Character I/O Interface

This block sits between a serial character terminal and a processor's accumulator. On the receive side, a keyboard delivers bits one at a time. They are qualified by a valid strobe and collected most significant bit first into a character register. When the last bit of a character has arrived, a ready flag rises. While that flag is up, the register is frozen: further keystroke bits are dropped. The processor copies the character out in parallel. It then pulses an accept strobe, which lowers the flag and reopens the register.

On the transmit side, a free flag starts high after reset, meaning the printer is idle. A parallel load strobe from the processor captures a character only while the flag is high. The load lowers the flag, and the character is streamed to the printer one bit per cycle, most significant bit first, with a valid strobe. The flag rises again in the cycle after the last bit has gone out. A load request made while the flag is low is dropped.

Top module: `term_char_if`

## Requirements
- R1: After reset, `rx_ready_o` is 0, `rx_data_o` is 0, `tx_free_o` is 1 and `pr_valid_o` is 0.
- R2: Each clock edge with `kb_valid_i`=1 and `rx_ready_o`=0 shifts `kb_bit_i` into bit 0 of `rx_data_o`, moving earlier bits toward bit 7, so the first bit sent ends in bit 7. The edge that takes the eighth such bit also sets `rx_ready_o`=1.
- R3: While `rx_ready_o`=1, `kb_valid_i` has no effect on `rx_data_o`, and no bit is counted toward the next character.
- R4: An edge with `rx_take_i`=1 while `rx_ready_o`=1 clears `rx_ready_o`. The next eight valid bits then form a new character.
- R5: `rx_take_i` while `rx_ready_o`=0 has no effect: a partly received character keeps its bit count.
- R6: An edge with `tx_load_i`=1 while `tx_free_o`=1 captures `tx_data_i` and clears `tx_free_o`. For the next eight cycles `pr_valid_o`=1, and `pr_bit_o` carries bit 7 down to bit 0 of the captured character, in that order.
- R7: In the cycle after the eighth serial bit, `tx_free_o` is 1 and `pr_valid_o` is 0.
- R8: `tx_load_i` while `tx_free_o`=0 is ignored: the serial stream in progress is unchanged.
- R9: `pr_valid_o` is never 1 while `tx_free_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kb_bit_i | input | 1 | Serial keyboard data bit |
| kb_valid_i | input | 1 | Keyboard bit qualifier |
| rx_take_i | input | 1 | Processor has accepted the received character |
| rx_data_o | output | 8 | Received character register |
| rx_ready_o | output | 1 | Input flag: a full character is waiting |
| tx_data_i | input | 8 | Character to print |
| tx_load_i | input | 1 | Parallel load request for the output register |
| tx_free_o | output | 1 | Output flag: printer is ready for a character |
| pr_bit_o | output | 1 | Serial printer data bit |
| pr_valid_o | output | 1 | Printer bit qualifier |

## Verification
A bit counter that is wrong on the receive side shows up as `rx_ready_o` rising one or more strobes early or late. It also shows as a character whose bits are rotated, visible on the very character being received. A receive register that is not locked shows up as a changed `rx_data_o` in the first cycle after a stray strobe. On the transmit side, a lost or doubled shift, or a load that slips through while busy, corrupts `pr_bit_o` within one cycle. A miscounted length moves the rise of `tx_free_o` away from the ninth cycle after the load.

// File: rtl/term_char_pkg.sv
package term_char_pkg;

    typedef enum logic [0:0] {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_phase_e;

endpackage

// File: rtl/term_rx_side.sv
module term_rx_side #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_bit_i,
    input  logic              kb_valid_i,
    input  logic              take_i,
    output logic [CHAR_W-1:0] data_o,
    output logic              ready_o
);
    localparam int CNT_W = (CHAR_W > 2) ? $clog2(CHAR_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] shreg;
        logic [CNT_W-1:0]  count;
        logic              full;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.full) begin
            // register locked; only the processor's accept reopens it
            if (take_i) begin
                st_d.full = 1'b0;
            end
        end else if (kb_valid_i) begin
            st_d.shreg = {st_q.shreg[CHAR_W-2:0], kb_bit_i};
            if (st_q.count == LAST_IDX) begin
                st_d.count = '0;
                st_d.full  = 1'b1;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.shreg;
    assign ready_o = st_q.full;

    AST_RX_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> $stable(data_o)) else $error("rx data changed while full"); // R3
    AST_RX_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && take_i) |=> !ready_o) else $error("accept did not clear flag"); // R4
    AST_RX_RISE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(kb_valid_i)) else $error("flag rose without a bit"); // R2
    AST_RX_IDLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && take_i && !kb_valid_i) |=> $stable(data_o)) else $error("idle accept touched data"); // R5
endmodule

// File: rtl/term_tx_side.sv
module term_tx_side
    import term_char_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] data_i,
    input  logic              load_i,
    output logic              free_o,
    output logic              bit_o,
    output logic              valid_o
);
    localparam int CNT_W = (CHAR_W > 2) ? $clog2(CHAR_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] shreg;
        logic [CNT_W-1:0]  count;
        tx_phase_e         phase;
        logic              free;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            TX_IDLE: begin
                if (load_i && st_q.free) begin
                    st_d.shreg = data_i;
                    st_d.count = '0;
                    st_d.phase = TX_SHIFT;
                    st_d.free  = 1'b0;
                end
            end
            TX_SHIFT: begin
                // loads arriving here are dropped
                st_d.shreg = {st_q.shreg[CHAR_W-2:0], 1'b0};
                if (st_q.count == LAST_IDX) begin
                    st_d.count = '0;
                    st_d.phase = TX_IDLE;
                    st_d.free  = 1'b1;
                end else begin
                    st_d.count = st_q.count + 1'b1;
                end
            end
            default: st_d.phase = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= TX_IDLE;
            st_q.free  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign free_o  = st_q.free;
    assign bit_o   = st_q.shreg[CHAR_W-1];
    assign valid_o = (st_q.phase == TX_SHIFT);

    AST_TX_FREE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        free_o |-> !valid_o) else $error("valid while free"); // R9
    AST_TX_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && free_o) |=> (!free_o && valid_o && bit_o == $past(data_i[CHAR_W-1]))) else $error("load did not start"); // R6
    AST_TX_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!free_o && valid_o) |=> (bit_o == $past(st_q.shreg[CHAR_W-2]))) else $error("stream disturbed"); // R8
    AST_TX_END_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(free_o) |-> $past(valid_o)) else $error("flag rose without a stream"); // R7
endmodule

// File: rtl/term_char_if.sv
module term_char_if #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_bit_i,
    input  logic              kb_valid_i,
    input  logic              rx_take_i,
    output logic [CHAR_W-1:0] rx_data_o,
    output logic              rx_ready_o,
    input  logic [CHAR_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic              tx_free_o,
    output logic              pr_bit_o,
    output logic              pr_valid_o
);
    term_rx_side #(.CHAR_W(CHAR_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .kb_bit_i   (kb_bit_i),
        .kb_valid_i (kb_valid_i),
        .take_i     (rx_take_i),
        .data_o     (rx_data_o),
        .ready_o    (rx_ready_o)
    );

    term_tx_side #(.CHAR_W(CHAR_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_i  (tx_data_i),
        .load_i  (tx_load_i),
        .free_o  (tx_free_o),
        .bit_o   (pr_bit_o),
        .valid_o (pr_valid_o)
    );
endmodule

// File: tb/term_char_if_bench.sv
`timescale 1ns/1ps
module term_char_if_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         kb_bit = 1'b0, kb_valid = 1'b0, rx_take = 1'b0;
    logic [W-1:0] rx_data;
    logic         rx_ready;
    logic [W-1:0] tx_data = '0;
    logic         tx_load = 1'b0;
    logic         tx_free, pr_bit, pr_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    term_char_if #(.CHAR_W(W)) u_term_char_if (
        .clk(clk), .rst_n(rst_n),
        .kb_bit_i(kb_bit), .kb_valid_i(kb_valid), .rx_take_i(rx_take),
        .rx_data_o(rx_data), .rx_ready_o(rx_ready),
        .tx_data_i(tx_data), .tx_load_i(tx_load), .tx_free_o(tx_free),
        .pr_bit_o(pr_bit), .pr_valid_o(pr_valid)
    );

    function automatic logic exp_bit(input logic [W-1:0] ch, input int idx);
        return ch[W-1-idx];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: inputs set at negedge, observed at next negedge
    task automatic kb_send(input logic b);
        kb_valid = 1'b1; kb_bit = b;
        @(negedge clk);
        kb_valid = 1'b0; kb_bit = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_char(input logic [W-1:0] ch, input int max_gap);
        for (int i = 0; i < W; i++) begin
            chk(rx_ready == 1'b0, "R2 ready early", rx_ready, 0);
            kb_send(exp_bit(ch, i));
            if (max_gap > 0) idle($urandom_range(max_gap, 0));
        end
        chk(rx_ready == 1'b1, "R2 ready after last bit", rx_ready, 1);
        chk(rx_data == ch, "R2 character", rx_data, ch);
    endtask

    task automatic rx_accept();
        rx_take = 1'b1;
        @(negedge clk);
        rx_take = 1'b0;
        chk(rx_ready == 1'b0, "R4 accept clears flag", rx_ready, 0);
    endtask

    // load and stream; optionally a stray load at bit position 'stray'
    task automatic tx_char(input logic [W-1:0] ch, input int stray);
        chk(tx_free == 1'b1, "R6 free before load", tx_free, 1);
        tx_data = ch; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0; tx_data = '0;
        for (int i = 0; i < W; i++) begin
            chk(pr_valid == 1'b1 && tx_free == 1'b0, "R6 streaming", {tx_free, pr_valid}, 1);
            chk(pr_bit == exp_bit(ch, i), (stray >= 0) ? "R8 bit" : "R6 bit", pr_bit, exp_bit(ch, i));
            if (i == stray) begin
                tx_data = ~ch; tx_load = 1'b1;
            end
            @(negedge clk);
            tx_load = 1'b0; tx_data = '0;
        end
        chk(tx_free == 1'b1 && pr_valid == 1'b0, "R7 free after last bit", {tx_free, pr_valid}, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] ch;
        logic [W-1:0] held;
        void'($urandom(32'h5eed_1234));
        idle(2);
        // R1 reset state
        chk(rx_ready == 1'b0, "R1 rx_ready", rx_ready, 0);
        chk(rx_data == '0, "R1 rx_data", rx_data, 0);
        chk(tx_free == 1'b1, "R1 tx_free", tx_free, 1);
        chk(pr_valid == 1'b0, "R1 pr_valid", pr_valid, 0);
        rst_n = 1'b1;
        idle(1);
        chk(tx_free == 1'b1 && rx_ready == 1'b0, "R1 after release", {tx_free, rx_ready}, 2);

        // R2 directed corner characters, back to back
        rx_char(8'h80, 0); rx_accept();
        rx_char(8'h01, 0); rx_accept();
        rx_char(8'hA5, 0);

        // R3 stray bits while full
        held = rx_data;
        for (int i = 0; i < 5; i++) begin
            kb_send(~held[i]);
            chk(rx_data == held, "R3 data locked", rx_data, held);
        end
        rx_accept();
        rx_char(8'h3C, 0); // R3: stray bits did not count toward this one
        rx_accept();

        // R5 accept while not ready
        for (int i = 0; i < 3; i++) kb_send(exp_bit(8'hC3, i));
        rx_take = 1'b1; @(negedge clk); rx_take = 1'b0;
        chk(rx_ready == 1'b0, "R5 still not ready", rx_ready, 0);
        for (int i = 3; i < W; i++) kb_send(exp_bit(8'hC3, i));
        chk(rx_ready == 1'b1 && rx_data == 8'hC3, "R5 partial count kept", rx_data, 8'hC3);
        rx_accept();

        // random receive traffic with gaps and stray bits
        for (int k = 0; k < 25; k++) begin
            ch = W'($urandom);
            rx_char(ch, 3);
            if ($urandom_range(1, 0) == 1) begin
                kb_send(1'($urandom));
                chk(rx_data == ch, "R3 random stray", rx_data, ch);
            end
            idle($urandom_range(2, 0));
            rx_accept();
        end

        // transmit: directed
        tx_char(8'h80, -1);
        tx_char(8'h01, -1);
        tx_char(8'hFF, 0);        // R8 stray load on first busy cycle
        tx_char(8'h5A, W-1);      // R8 stray load on last bit cycle
        // R9 idle: free with no valid
        idle(3);
        chk(tx_free == 1'b1 && pr_valid == 1'b0, "R9 idle quiet", {tx_free, pr_valid}, 2);

        // random transmit
        for (int k = 0; k < 25; k++) begin
            ch = W'($urandom);
            tx_char(ch, ($urandom_range(1, 0) == 1) ? int'($urandom_range(W-1, 0)) : -1);
            idle($urandom_range(3, 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule